// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block works out the data-memory address for an indirect load or store. It also works out the new pointer value to write back to the register file. The pointer comes from one of three fixed register pairs. The caller gives the pair's two bytes, the pointer's extension byte, a pointer select, an addressing mode and a 6-bit unsigned displacement.

One cycle after a request, the block returns:
- the effective address;
- a write-back value split into low, high and extension bytes;
- a write-back enable;
- the index of the low register of the pair;
- an error flag for combinations that are not allowed.

There are four addressing modes:
- **Plain:** the pointer is used as it is.
- **Post-increment:** the address is taken first, then the pointer is stepped up.
- **Pre-decrement:** the pointer is stepped down first, and the new value is the address.
- **Displacement:** the offset is added to the pointer, and the pointer is left unchanged.

Displacement is allowed only on the second and third pointers. With the extension enabled, the pointer is 24 bits wide: the extension byte sits above the 16-bit pair. Stepping and offsets then carry through into the extension byte. With the extension disabled, the extension input is ignored and all arithmetic wraps at 16 bits.

Top module: `ptr_agen`

## Requirements
- R1: While reset is high and in the first cycle after it, `vld`, `wb_en` and `err` are 0, and `addr` and the write-back bytes are 0.
- R2: A request sampled at a rising edge gives `vld`=1 after that edge. A cycle with `req`=0 gives `vld`, `wb_en` and `err` all 0, and every data output 0.
- R3: The select codes are 0, 1 and 2 for the pointers held in register pairs 27:26, 29:28 and 31:30. The odd register holds the high byte, so the pointer is `{pair_hi,pair_lo}`. For these selects, `wb_reg` reports 26, 28 or 30.
- R4: Mode 0 (plain) gives `addr` = `{ext_val,pointer}` and `wb_en`=0.
- R5: Mode 1 (post-increment) gives `addr` = the current extended pointer. It sets `wb_en`=1, with write-back = pointer + 1.
- R6: Mode 2 (pre-decrement) gives write-back = pointer − 1 and `wb_en`=1. `addr` equals that decremented value.
- R7: Mode 3 (displacement) on select 1 or 2 gives `addr` = extended pointer + `disp` (0..63) and `wb_en`=0.
- R8: Displacement on select 0, or any request with select code 3, gives `err`=1, `wb_en`=0, and zeros on `addr`, on the write-back bytes and on `wb_reg`.
- R9: With `EXT_EN`=1, increment, decrement and offset carry across the full 24 bits including the extension byte, and wrap at 2^24.
- R10: With `EXT_EN`=0, `ext_val` has no effect, arithmetic wraps at 16 bits, and the `addr` upper byte and `wb_ext` are 0.
- R11: When `wb_en`=0 the write-back bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; the inputs are sampled when it is high |
| ptr_sel | input | 2 | Pointer select: 0, 1, 2 for pairs 27:26, 29:28, 31:30; 3 is illegal |
| mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp | input | DISP_W (6) | Unsigned displacement |
| pair_lo | input | PTR_W/2 (8) | Pointer low byte (even register) |
| pair_hi | input | PTR_W/2 (8) | Pointer high byte (odd register) |
| ext_val | input | EXT_W (8) | Extension byte of the selected pointer |
| vld | output | 1 | A result is present |
| addr | output | PTR_W+EXT_W (24) | Effective address |
| wb_en | output | 1 | Write the pointer back |
| wb_reg | output | 5 | Index of the pair's low register |
| wb_lo | output | PTR_W/2 (8) | Write-back low byte |
| wb_hi | output | PTR_W/2 (8) | Write-back high byte |
| wb_ext | output | EXT_W (8) | Write-back extension byte |
| err | output | 1 | Illegal select or mode combination |

## Verification
The assertions check on every cycle that:
- an error never comes with a write-back;
- an idle cycle is quiet;
- the write-back enable follows the requested mode;
- post-increment returns the old pointer as the address;
- pre-decrement returns the write-back value as the address.

Some behaviour can only be shown by the bench's sweeps. These are the exact arithmetic values, the carry into the extension byte, the 16-bit wrap of the narrow variant, the fixed pair indices and the displacement range ends. The sweeps run a wide and a narrow instance side by side over every select and mode, with pointer values at the byte boundaries.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;

    localparam int REG_IDX_W = 5;

    typedef enum logic [1:0] {
        SEL_X    = 2'd0,
        SEL_Y    = 2'd1,
        SEL_Z    = 2'd2,
        SEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } amode_e;

    typedef struct packed {
        logic legal;       // combination may proceed
        logic step_down;   // step direction: 1 = decrement
        logic addr_after;  // address is the stepped value
        logic use_disp;    // address is pointer + displacement
        logic wb;          // pointer is written back
    } ctl_t;

    function automatic logic [REG_IDX_W-1:0] pair_base(ptr_sel_e s);
        case (s)
            SEL_X:   return REG_IDX_W'(26);
            SEL_Y:   return REG_IDX_W'(28);
            SEL_Z:   return REG_IDX_W'(30);
            default: return '0;
        endcase
    endfunction

    function automatic logic disp_allowed(ptr_sel_e s);
        return (s == SEL_Y) || (s == SEL_Z);
    endfunction

endpackage

// File: rtl/ptr_agen_ctl.sv
module ptr_agen_ctl
    import ptr_agen_pkg::*;
(
    input  ptr_sel_e sel_i,
    input  amode_e   mode_i,
    output ctl_t     ctl_o
);

    logic sel_ok;

    always_comb begin
        sel_ok = (sel_i != SEL_NONE);
        ctl_o  = '0;
        case (mode_i)
            AM_PLAIN: begin
                ctl_o.legal = sel_ok;
            end
            AM_POSTINC: begin
                ctl_o.legal = sel_ok;
                ctl_o.wb    = sel_ok;
            end
            AM_PREDEC: begin
                ctl_o.legal      = sel_ok;
                ctl_o.wb         = sel_ok;
                ctl_o.step_down  = 1'b1;
                ctl_o.addr_after = 1'b1;
            end
            AM_DISP: begin
                ctl_o.legal    = disp_allowed(sel_i);
                ctl_o.use_disp = 1'b1;
            end
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/ptr_agen_step.sv
module ptr_agen_step #(
    parameter int PTR_W  = 16,
    parameter int EXT_W  = 8,
    parameter bit EXT_EN = 1'b1
) (
    input  logic [PTR_W-1:0]       ptr_i,
    input  logic [EXT_W-1:0]       ext_i,
    input  logic                   down_i,
    output logic [PTR_W+EXT_W-1:0] cur_o,
    output logic [PTR_W+EXT_W-1:0] nxt_o
);

    localparam int FULL = PTR_W + EXT_W;
    localparam int SPAN = EXT_EN ? FULL : PTR_W;
    localparam logic [SPAN-1:0] ONE = {{(SPAN-1){1'b0}}, 1'b1};

    logic [SPAN-1:0] span;
    logic [SPAN-1:0] span_nxt;

    generate
        if (EXT_EN) begin : g_wide
            assign span = {ext_i, ptr_i};
        end else begin : g_narrow
            assign span = ptr_i;
        end
    endgenerate

    always_comb begin
        span_nxt = down_i ? (span - ONE) : (span + ONE);
    end

    assign cur_o = FULL'(span);
    assign nxt_o = FULL'(span_nxt);

endmodule

// File: rtl/ptr_agen_disp.sv
module ptr_agen_disp #(
    parameter int PTR_W  = 16,
    parameter int EXT_W  = 8,
    parameter int DISP_W = 6,
    parameter bit EXT_EN = 1'b1
) (
    input  logic [PTR_W+EXT_W-1:0] base_i,
    input  logic [DISP_W-1:0]      disp_i,
    output logic [PTR_W+EXT_W-1:0] sum_o
);

    localparam int FULL = PTR_W + EXT_W;
    localparam int SPAN = EXT_EN ? FULL : PTR_W;

    logic [SPAN-1:0] sum_span;

    always_comb begin
        sum_span = base_i[SPAN-1:0] + SPAN'(disp_i);
    end

    assign sum_o = FULL'(sum_span);

endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
    import ptr_agen_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int EXT_W  = 8,
    parameter int DISP_W = 6,
    parameter bit EXT_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [1:0]             ptr_sel,
    input  logic [1:0]             mode,
    input  logic [DISP_W-1:0]      disp,
    input  logic [PTR_W/2-1:0]     pair_lo,
    input  logic [PTR_W/2-1:0]     pair_hi,
    input  logic [EXT_W-1:0]       ext_val,
    output logic                   vld,
    output logic [PTR_W+EXT_W-1:0] addr,
    output logic                   wb_en,
    output logic [REG_IDX_W-1:0]   wb_reg,
    output logic [PTR_W/2-1:0]     wb_lo,
    output logic [PTR_W/2-1:0]     wb_hi,
    output logic [EXT_W-1:0]       wb_ext,
    output logic                   err
);

    localparam int FULL = PTR_W + EXT_W;
    localparam int HALF = PTR_W / 2;

    ptr_sel_e        sel_e;
    amode_e          mode_e;
    ctl_t            ctl;
    logic [FULL-1:0] cur_full;
    logic [FULL-1:0] nxt_full;
    logic [FULL-1:0] disp_sum;
    logic [FULL-1:0] addr_n;
    logic [FULL-1:0] wb_n;

    assign sel_e  = ptr_sel_e'(ptr_sel);
    assign mode_e = amode_e'(mode);

    ptr_agen_ctl u_ctl (
        .sel_i  (sel_e),
        .mode_i (mode_e),
        .ctl_o  (ctl)
    );

    ptr_agen_step #(
        .PTR_W  (PTR_W),
        .EXT_W  (EXT_W),
        .EXT_EN (EXT_EN)
    ) u_step (
        .ptr_i  ({pair_hi, pair_lo}),
        .ext_i  (ext_val),
        .down_i (ctl.step_down),
        .cur_o  (cur_full),
        .nxt_o  (nxt_full)
    );

    ptr_agen_disp #(
        .PTR_W  (PTR_W),
        .EXT_W  (EXT_W),
        .DISP_W (DISP_W),
        .EXT_EN (EXT_EN)
    ) u_disp (
        .base_i (cur_full),
        .disp_i (disp),
        .sum_o  (disp_sum)
    );

    always_comb begin
        if (!ctl.legal)          addr_n = '0;
        else if (ctl.use_disp)   addr_n = disp_sum;
        else if (ctl.addr_after) addr_n = nxt_full;
        else                     addr_n = cur_full;
        wb_n = ctl.wb ? nxt_full : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            vld    <= 1'b0;
            addr   <= '0;
            wb_en  <= 1'b0;
            wb_reg <= '0;
            wb_lo  <= '0;
            wb_hi  <= '0;
            wb_ext <= '0;
            err    <= 1'b0;
        end else begin
            vld    <= 1'b1;
            addr   <= addr_n;
            wb_en  <= ctl.wb;
            wb_reg <= ctl.legal ? pair_base(sel_e) : '0;
            wb_lo  <= wb_n[HALF-1:0];
            wb_hi  <= wb_n[PTR_W-1:HALF];
            wb_ext <= wb_n[FULL-1:PTR_W];
            err    <= !ctl.legal;
        end
    end

    AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (rst)
        err |-> (!wb_en && addr == '0)) else $error("err with write-back"); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !vld |-> (!wb_en && !err)) else $error("idle output active"); // R2

    AST_WB_MODE: assert property (@(posedge clk) disable iff (rst)
        (req && !rst) |=> (wb_en == (($past(mode) == 2'd1 || $past(mode) == 2'd2)
                                     && $past(ptr_sel) != 2'd3)))
        else $error("write-back enable mismatch"); // R5

    AST_POST_ADDR: assert property (@(posedge clk) disable iff (rst)
        (req && !rst && mode == 2'd1 && ptr_sel != 2'd3) |=>
        (addr == $past(cur_full))) else $error("post-increment address"); // R5

    AST_PRE_ADDR: assert property (@(posedge clk) disable iff (rst)
        (wb_en && addr_after_q) |-> (addr == {wb_ext, wb_hi, wb_lo}))
        else $error("pre-decrement address"); // R6

    logic addr_after_q;
    always_ff @(posedge clk) begin
        if (rst) addr_after_q <= 1'b0;
        else     addr_after_q <= req && ctl.addr_after;
    end

endmodule

// File: tb/ptr_agen_test.sv
module ptr_agen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [1:0]  mode = '0;
    logic [5:0]  disp = '0;
    logic [7:0]  pair_lo = '0, pair_hi = '0, ext_val = '0;

    logic        vld, wb_en, err, vld_n, wb_en_n, err_n;
    logic [23:0] addr, addr_n;
    logic [4:0]  wb_reg, wb_reg_n;
    logic [7:0]  wb_lo, wb_hi, wb_ext, wb_lo_n, wb_hi_n, wb_ext_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ptr_agen #(.EXT_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .req(req), .ptr_sel(ptr_sel), .mode(mode),
        .disp(disp), .pair_lo(pair_lo), .pair_hi(pair_hi), .ext_val(ext_val),
        .vld(vld), .addr(addr), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_lo(wb_lo), .wb_hi(wb_hi), .wb_ext(wb_ext), .err(err)
    );

    ptr_agen #(.EXT_EN(1'b0)) uut_narrow (
        .clk(clk), .rst(rst), .req(req), .ptr_sel(ptr_sel), .mode(mode),
        .disp(disp), .pair_lo(pair_lo), .pair_hi(pair_hi), .ext_val(ext_val),
        .vld(vld_n), .addr(addr_n), .wb_en(wb_en_n), .wb_reg(wb_reg_n),
        .wb_lo(wb_lo_n), .wb_hi(wb_hi_n), .wb_ext(wb_ext_n), .err(err_n)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected outcome, width w = 24 (wide) or 16 (narrow)
    task automatic expect_op(input int w, input logic [1:0] s, input logic [1:0] m,
                             input logic [5:0] q, input logic [15:0] p, input logic [7:0] e,
                             output logic [66:0] res);
        logic [23:0] cur, nxt, a, wbv;
        logic [23:0] mask;
        logic        we, er;
        logic [4:0]  ri;
        mask = (w == 24) ? 24'hFFFFFF : 24'h00FFFF;
        cur  = (w == 24) ? {e, p} : {8'h00, p};
        er   = (s == 2'd3) || (m == 2'd3 && s == 2'd0);
        we   = !er && (m == 2'd1 || m == 2'd2);
        nxt  = (m == 2'd2) ? ((cur - 24'd1) & mask) : ((cur + 24'd1) & mask);
        if (er)            a = '0;
        else if (m == 2'd3) a = (cur + {18'd0, q}) & mask;
        else if (m == 2'd2) a = nxt;
        else                a = cur;
        wbv = we ? nxt : '0;
        ri  = er ? 5'd0 : (5'd26 + {2'b0, s, 1'b0});
        res = {1'b1, we, er, ri, a, wbv, 8'h00};
    endtask

    task automatic run_op(input logic [1:0] s, input logic [1:0] m, input logic [5:0] q,
                          input logic [15:0] p, input logic [7:0] e);
        logic [66:0] ew, en;
        ptr_sel = s; mode = m; disp = q; pair_hi = p[15:8]; pair_lo = p[7:0];
        ext_val = e; req = 1'b1;
        @(negedge clk);
        expect_op(24, s, m, q, p, e, ew);
        expect_op(16, s, m, q, p, e, en);
        // R3 R4 R5 R6 R7 R8 R9 R11 wide instance
        check("R2_vld", {63'd0, vld}, 64'd1);
        check("R3_wb_reg", {59'd0, wb_reg}, {59'd0, ew[60:56]});
        check("R8_err", {63'd0, err}, {63'd0, ew[61]});
        check("R5_R6_wb_en", {63'd0, wb_en}, {63'd0, ew[62]});
        check(m == 2'd3 ? "R7_addr" : (m == 2'd2 ? "R6_addr" : "R4_R5_addr"),
              {40'd0, addr}, {40'd0, ew[55:32]});
        check("R9_R11_wb", {40'd0, wb_ext, wb_hi, wb_lo}, {40'd0, ew[31:8]});
        // R10 narrow instance
        check("R10_addr", {40'd0, addr_n}, {40'd0, en[55:32]});
        check("R10_wb", {40'd0, wb_ext_n, wb_hi_n, wb_lo_n}, {40'd0, en[31:8]});
        check("R10_flags", {61'd0, wb_en_n, err_n, vld_n}, {61'd0, en[62], en[61], 1'b1});
    endtask

    initial begin
        logic [15:0] ptrs [5];
        logic [7:0]  exts [3];
        logic [5:0]  qs   [4];
        ptrs = '{16'h0000, 16'hFFFF, 16'h00FF, 16'h01C3, 16'hFF00};
        exts = '{8'h00, 8'hFF, 8'h12};
        qs   = '{6'd0, 6'd1, 6'd31, 6'd63};

        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1_rst", {38'd0, vld, wb_en, err, addr}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1_after", {14'd0, vld, wb_en, err, wb_reg, addr, wb_ext, wb_hi, wb_lo}, 64'd0);

        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++)
                for (int pi = 0; pi < 5; pi++)
                    for (int ei = 0; ei < 3; ei++)
                        for (int qi = 0; qi < 4; qi++)
                            run_op(2'(s), 2'(m), qs[qi], ptrs[pi], exts[ei]);

        // R9 explicit carry into extension, and borrow wrap at 2^24
        run_op(2'd2, 2'd1, 6'd0, 16'hFFFF, 8'h12);
        check("R9_carry", {40'd0, wb_ext, wb_hi, wb_lo}, 64'h130000);
        run_op(2'd1, 2'd2, 6'd0, 16'h0000, 8'h00);
        check("R9_wrap", {40'd0, addr}, 64'hFFFFFF);
        run_op(2'd1, 2'd3, 6'd63, 16'hFFF0, 8'h05);
        check("R9_disp", {40'd0, addr}, 64'h06002F);

        // R2 idle cycle after a request
        req = 1'b0;
        @(negedge clk);
        check("R2_idle", {14'd0, vld, wb_en, err, wb_reg, addr, wb_ext, wb_hi, wb_lo}, 64'd0);
        check("R2_idle_narrow", {61'd0, vld_n, wb_en_n, err_n}, 64'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule